// File: doc/BRIEF.md
# Instruction Fetch Read Port

This block sits between a small processor core and an AXI4-Lite fabric and fetches instruction words on the core's behalf. The core raises a request strobe with a program-counter value. The port forces the address onto a 32-bit word boundary and runs the read-address handshake. It then waits for the read-data beat and returns the 32-bit word to the core as a single-cycle response. The response carries a fault flag when the fabric signals an error.

Only one fetch is ever outstanding. While a fetch is in progress the port reports itself busy and ignores further requests. The port never writes. All write-address, write-data and write-response outputs are held inactive, and the read-data ready is held high at all times. Each fetch uses exactly one address beat and one data beat, with no bursts. A synchronous active-low reset returns the port to idle and abandons any fetch in progress.

Top module: `ifetch_port`

## Requirements
- R1: The write side is inert at all times: awvalid, wvalid and bready are 0, and awaddr, awprot, wdata and wstrb are all zero.
- R2: rready is 1 in every cycle, including during reset.
- R3: A req sampled while busy is 0 is accepted. From the next cycle arvalid is 1 and araddr equals addr with bits [1:0] forced to zero.
- R4: While arvalid is 1 and arready is 0, arvalid, araddr and arprot stay unchanged. In the cycle after arready is sampled 1, arvalid is 0.
- R5: arprot is 3'b100 (bit 2 set marks an instruction access, bits 1 and 0 clear).
- R6: busy is 1 from the cycle after a request is accepted up to and including the cycle in which rvalid is accepted. A req seen while busy is 1 is dropped: it changes neither araddr nor the number of address beats.
- R7: When rvalid is sampled 1 after the address handshake, rsp_valid is 1 for exactly the next cycle, with rsp_instr equal to the sampled rdata. busy is 0 in that cycle.
- R8: rsp_fault is 1 in the response cycle exactly when the sampled rresp is non-zero (any of 2'b01, 2'b10, 2'b11), and 0 for 2'b00.
- R9: rvalid sampled while idle, or before the address handshake completes, produces no response.
- R10: rst_n sampled 0 at a clock edge leaves arvalid, busy and rsp_valid at 0 from then on. A data beat arriving after such a reset produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Core fetch request strobe |
| addr | input | 32 | Core program-counter address |
| busy | output | 1 | A fetch is in progress; req is ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_instr | output | 32 | Fetched instruction word |
| rsp_fault | output | 1 | Instruction access fault for this response |
| awaddr | output | 32 | Write address, held zero |
| awprot | output | 3 | Write protection, held zero |
| awvalid | output | 1 | Write address valid, held low |
| awready | input | 1 | Write address ready, unused |
| wdata | output | 32 | Write data, held zero |
| wstrb | output | 4 | Write strobes, held zero |
| wvalid | output | 1 | Write data valid, held low |
| wready | input | 1 | Write data ready, unused |
| bresp | input | 2 | Write response, unused |
| bvalid | input | 1 | Write response valid, unused |
| bready | output | 1 | Write response ready, held low |
| araddr | output | 32 | Word-aligned fetch address |
| arprot | output | 3 | Fetch protection attributes |
| arvalid | output | 1 | Fetch address valid |
| arready | input | 1 | Fetch address ready |
| rdata | input | 32 | Returned instruction word |
| rresp | input | 2 | Read response code |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready, held high |

## Verification
The bench drives misaligned program counters and checks that the low address bits are cleared. A port that failed to do this would present a byte address to the fabric. It stalls arready for several cycles and checks that arvalid and araddr do not move, which a port that dropped or changed its request would fail. It also raises req during a pending fetch, where a port without a single-outstanding guard would overwrite the address or issue a second beat. Each non-zero rresp code is tried, so a decoder that tested only one bit would miss a fault. The bench also sends stray rvalid beats while idle, in the address phase and after a mid-fetch reset. A port that accepted data out of phase would emit a spurious response.

// File: rtl/ifetch_pkg.sv
// Package ifetch_pkg
// Shared types and constants for the instruction fetch read port.
// Assumes a 32-bit data bus; protection encoding follows AXI (bit 2 = instruction).
package ifetch_pkg;

    // Fetch sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no fetch pending
        ST_ADDR = 2'd1,   // address beat presented, waiting for arready
        ST_DATA = 2'd2    // address accepted, waiting for rvalid
    } fetch_state_e;

    // Protection attributes for an unprivileged, secure instruction access
    localparam logic [2:0] PROT_INSTR = 3'b100;

endpackage

// File: rtl/ifetch_ar_ctrl.sv
// Module ifetch_ar_ctrl
// Sequences one fetch at a time: accepts a core request while idle, holds the
// aligned address beat until arready, then waits for the data beat.
// Assumes the fabric returns rvalid only after the address handshake.
module ifetch_ar_ctrl
    import ifetch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              arready,
    input  logic              rvalid,
    output logic              arvalid,
    output logic [ADDR_W-1:0] araddr,
    output logic              busy,
    output logic              data_phase
);

    fetch_state_e      state_q;
    logic [ADDR_W-1:0] addr_q;

    // Advance the fetch state on handshakes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (req)     state_q <= ST_ADDR;
                ST_ADDR: if (arready) state_q <= ST_DATA;
                ST_DATA: if (rvalid)  state_q <= ST_IDLE;
                default:              state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the word-aligned address only when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (state_q == ST_IDLE && req) begin
            addr_q <= {addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
    end

    // Decode state into handshake outputs
    always_comb begin
        arvalid    = (state_q == ST_ADDR);
        busy       = (state_q != ST_IDLE);
        data_phase = (state_q == ST_DATA);
        araddr     = addr_q;
    end

    // R3: an idle request starts an address beat next cycle
    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> arvalid);

    // R4: a stalled address beat keeps its address and stays valid
    a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr)));

    // R4: after the handshake the beat is withdrawn and data is awaited
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> (!arvalid && data_phase));

    // R6: a request during a pending fetch leaves the address untouched
    a_r6_ignore_req: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(araddr));

endmodule

// File: rtl/ifetch_rsp_dec.sv
// Module ifetch_rsp_dec
// Registers the returned instruction word and turns the read response code
// into an access-fault flag, emitting a single-cycle strobe to the core.
// Assumes accept is high for at most one cycle per fetch.
module ifetch_rsp_dec #(
    parameter int DATA_W = 32,
    parameter int RESP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] rdata,
    input  logic [RESP_W-1:0] rresp,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_instr,
    output logic              rsp_fault
);

    // Pulse the response strobe for one cycle per accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= accept;
        end
    end

    // Hold instruction and fault flag from the accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_instr <= '0;
            rsp_fault <= 1'b0;
        end else if (accept) begin
            rsp_instr <= rdata;
            rsp_fault <= (rresp != '0);
        end
    end

    // R7: the response strobe never lasts two cycles
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: an OKAY response never yields a fault
    a_r8_okay_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rresp == '0) |=> !rsp_fault);

endmodule

// File: rtl/ifetch_wr_tieoff.sv
// Module ifetch_wr_tieoff
// Holds every write-side output inactive; the port never writes.
// Write-side inputs are accepted only to keep the interface complete.
module ifetch_wr_tieoff #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                awready,
    input  logic                wready,
    input  logic [1:0]          bresp,
    input  logic                bvalid,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [2:0]          awprot,
    output logic                awvalid,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wvalid,
    output logic                bready
);

    logic unused_wr_inputs;

    // Drive constant idle values on the write channels
    always_comb begin
        awaddr           = '0;
        awprot           = '0;
        awvalid          = 1'b0;
        wdata            = '0;
        wstrb            = '0;
        wvalid           = 1'b0;
        bready           = 1'b0;
        unused_wr_inputs = ^{awready, wready, bresp, bvalid};
    end

endmodule

// File: rtl/ifetch_port.sv
// Module ifetch_port
// Read-only AXI4-Lite manager port that fetches one 32-bit instruction word
// per core request, with at most one fetch outstanding.
// Assumes a word-addressed instruction space and a fabric that orders rvalid
// after the address handshake.
module ifetch_port
    import ifetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int RESP_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [ADDR_W-1:0]   addr,
    output logic                busy,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_instr,
    output logic                rsp_fault,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [2:0]          awprot,
    output logic                awvalid,
    input  logic                awready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wvalid,
    input  logic                wready,
    input  logic [RESP_W-1:0]   bresp,
    input  logic                bvalid,
    output logic                bready,
    output logic [ADDR_W-1:0]   araddr,
    output logic [2:0]          arprot,
    output logic                arvalid,
    input  logic                arready,
    input  logic [DATA_W-1:0]   rdata,
    input  logic [RESP_W-1:0]   rresp,
    input  logic                rvalid,
    output logic                rready
);

    localparam int ALIGN_BITS = $clog2(DATA_W / 8);

    logic data_phase;
    logic beat_accept;

    ifetch_ar_ctrl #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_ar_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .addr       (addr),
        .arready    (arready),
        .rvalid     (rvalid),
        .arvalid    (arvalid),
        .araddr     (araddr),
        .busy       (busy),
        .data_phase (data_phase)
    );

    ifetch_rsp_dec #(
        .DATA_W (DATA_W),
        .RESP_W (RESP_W)
    ) u_rsp_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (beat_accept),
        .rdata     (rdata),
        .rresp     (rresp),
        .rsp_valid (rsp_valid),
        .rsp_instr (rsp_instr),
        .rsp_fault (rsp_fault)
    );

    ifetch_wr_tieoff #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr_tieoff (
        .awready (awready),
        .wready  (wready),
        .bresp   (bresp[1:0]),
        .bvalid  (bvalid),
        .awaddr  (awaddr),
        .awprot  (awprot),
        .awvalid (awvalid),
        .wdata   (wdata),
        .wstrb   (wstrb),
        .wvalid  (wvalid),
        .bready  (bready)
    );

    // Data beat is taken only while waiting for it; ready is always high
    always_comb begin
        beat_accept = data_phase && rvalid;
        rready      = 1'b1;
        arprot      = PROT_INSTR;
    end

    // R9: no response follows a beat seen outside the data phase
    a_r9_stray_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_phase) |=> !rsp_valid);

    // R6: busy drops in the response cycle
    a_r6_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

endmodule

// File: tb/ifetch_port_tb_top.sv
`timescale 1ns/1ps
module ifetch_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [31:0] addr;
    logic        busy, rsp_valid, rsp_fault;
    logic [31:0] rsp_instr;
    logic [31:0] awaddr, wdata, araddr;
    logic [2:0]  awprot, arprot;
    logic        awvalid, wvalid, bready, arvalid, rready;
    logic [3:0]  wstrb;
    logic        arready, rvalid;
    logic [31:0] rdata;
    logic [1:0]  rresp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ifetch_port dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_instr(rsp_instr), .rsp_fault(rsp_fault),
        .awaddr(awaddr), .awprot(awprot), .awvalid(awvalid), .awready(1'b0),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(1'b0),
        .bresp(2'b00), .bvalid(1'b0), .bready(bready),
        .araddr(araddr), .arprot(arprot), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] word;
        logic [1:0]  resp;
        logic [3:0]  ar_wait;
        logic [3:0]  r_wait;
        logic        poke;     // raise req while the fetch is pending
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'h0000_0013, 2'b00, 4'd0, 4'd0, 1'b0},
        '{32'h0000_2003, 32'hDEAD_BEEF, 2'b00, 4'd3, 4'd1, 1'b1},
        '{32'h8000_0001, 32'h1234_5678, 2'b10, 4'd1, 4'd4, 1'b0},
        '{32'hFFFF_FFFE, 32'hA5A5_5A5A, 2'b01, 4'd0, 4'd2, 1'b1},
        '{32'h0000_0044, 32'h0FF0_0FF0, 2'b11, 4'd5, 4'd0, 1'b0},
        '{32'h1357_9BDF, 32'hCAFE_F00D, 2'b00, 4'd2, 4'd3, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 2'b00, 4'd0, 4'd0, 1'b0}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle_sides(input string when);
        check(awvalid == 0 && wvalid == 0 && bready == 0, {"R1 write valids ", when},
              {awvalid, wvalid, bready}, 0);
        check(awaddr == 0 && awprot == 0 && wdata == 0 && wstrb == 0,
              {"R1 write payload ", when}, {awaddr, wdata}, 0);
        check(rready == 1'b1, {"R2 rready ", when}, rready, 1);
    endtask

    task automatic run_fetch(input vec_t v);
        @(negedge clk);
        req  = 1'b1;
        addr = v.pc;
        @(negedge clk);
        req  = 1'b0;
        addr = 32'h0;
        check(arvalid == 1'b1, "R3 arvalid after req", arvalid, 1);
        check(araddr == {v.pc[31:2], 2'b00}, "R3 aligned araddr", araddr, {v.pc[31:2], 2'b00});
        check(arprot == 3'b100, "R5 arprot", arprot, 3'b100);
        check(busy == 1'b1, "R6 busy in address phase", busy, 1);
        for (int i = 0; i < v.ar_wait; i++) begin
            if (v.poke && i == 0) begin
                req = 1'b1; addr = ~v.pc;
            end
            if (i == 1) begin
                rvalid = 1'b1; rdata = 32'h5555_AAAA; rresp = 2'b00;
            end
            @(negedge clk);
            req = 1'b0; rvalid = 1'b0;
            check(arvalid == 1'b1 && araddr == {v.pc[31:2], 2'b00} && arprot == 3'b100,
                  "R4 address beat held", {arvalid, araddr}, {1'b1, v.pc[31:2], 2'b00});
            check(rsp_valid == 1'b0, "R9 no response in address phase", rsp_valid, 0);
        end
        arready = 1'b1;
        @(negedge clk);
        arready = 1'b0;
        check(arvalid == 1'b0, "R4 arvalid dropped after handshake", arvalid, 0);
        for (int i = 0; i < v.r_wait; i++) begin
            if (v.poke) begin
                req = 1'b1; addr = 32'h0000_0F00;
            end
            @(negedge clk);
            req = 1'b0;
            check(busy == 1'b1 && arvalid == 1'b0 && araddr == {v.pc[31:2], 2'b00},
                  "R6 req ignored while busy", {busy, arvalid, araddr},
                  {2'b10, v.pc[31:2], 2'b00});
            check(rsp_valid == 1'b0, "R7 no early response", rsp_valid, 0);
        end
        rvalid = 1'b1; rdata = v.word; rresp = v.resp;
        @(negedge clk);
        rvalid = 1'b0; rdata = 32'h0; rresp = 2'b00;
        check(rsp_valid == 1'b1 && rsp_instr == v.word, "R7 response word",
              {rsp_valid, rsp_instr}, {1'b1, v.word});
        check(rsp_fault == (v.resp != 2'b00), "R8 fault flag", rsp_fault, v.resp != 2'b00);
        check(busy == 1'b0, "R6 busy clear in response cycle", busy, 0);
        @(negedge clk);
        check(rsp_valid == 1'b0 && arvalid == 1'b0, "R7 single pulse, no extra beat",
              {rsp_valid, arvalid}, 0);
        check_idle_sides("after fetch");
    endtask

    initial begin
        rst_n = 1'b0; req = 1'b0; addr = '0;
        arready = 1'b0; rvalid = 1'b0; rdata = '0; rresp = '0;
        repeat (3) @(negedge clk);
        check(arvalid == 0 && busy == 0 && rsp_valid == 0, "R10 reset state",
              {arvalid, busy, rsp_valid}, 0);
        check_idle_sides("in reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) run_fetch(VECS[k]);

        // R9: stray data beat while idle
        rvalid = 1'b1; rdata = 32'h7777_7777;
        @(negedge clk);
        rvalid = 1'b0;
        check(rsp_valid == 1'b0 && busy == 1'b0, "R9 idle beat ignored", {rsp_valid, busy}, 0);

        // R3: back-to-back request in the response cycle
        @(negedge clk);
        req = 1'b1; addr = 32'h0000_0106;
        @(negedge clk);
        req = 1'b0;
        arready = 1'b1;
        @(negedge clk);
        arready = 1'b0;
        rvalid = 1'b1; rdata = 32'h0000_0001; rresp = 2'b00;
        @(negedge clk);
        rvalid = 1'b0;
        req = 1'b1; addr = 32'h0000_0108;
        check(rsp_valid == 1'b1 && rsp_instr == 32'h1, "R7 first of pair", rsp_instr, 1);
        @(negedge clk);
        req = 1'b0;
        check(arvalid == 1'b1 && araddr == 32'h0000_0108, "R3 request in response cycle",
              araddr, 32'h108);
        arready = 1'b1;
        @(negedge clk);
        arready = 1'b0;

        // R10: reset in the data phase, then a late beat
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(arvalid == 0 && busy == 0 && rsp_valid == 0, "R10 reset drops fetch",
              {arvalid, busy, rsp_valid}, 0);
        rvalid = 1'b1; rdata = 32'h9999_9999; rresp = 2'b10;
        @(negedge clk);
        rvalid = 1'b0;
        check(rsp_valid == 1'b0, "R10 late beat after reset ignored", rsp_valid, 0);

        // R10: reset while the address beat is stalled
        req = 1'b1; addr = 32'h0000_0200;
        @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(arvalid == 1'b0 && busy == 1'b0, "R10 reset withdraws address beat",
              {arvalid, busy}, 0);
        @(negedge clk);
        check_idle_sides("at end");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule